// File: doc/BRIEF.md
# Processor Idle-State Clock Sequencer

This block follows the processor through its idle levels C0 to C4 and drives the clock-control sideband lines that go with each level. A read of one of three idle-level registers (levels 2, 3 and 4) in C0 moves the processor to a deeper state. An auto-halt indication moves it to C1. A single-cycle break event brings it back to C0 from any idle level. Two configuration bits change the mapping. One makes a level-3 read go to C4. The other lets a bus-master snoop request take a deep state (C3 or C4) up to C2 for as long as the snoop lasts, after which the block returns to the deep state it left.

The sideband lines are a stop-clock request, a stop-CPU-clock request, a deeper-sleep request, a regulator low-voltage request and a C4 alert. The first three are raised and lowered one step per cycle in a fixed order. The last two together tell the voltage regulator whether to hold low voltage, ramp up slowly or run at normal voltage.

Top module: `cstate_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, the reported state is C0 (code 0) and every output is low.
- R2: In C0, a level-2 read with no level-3 or level-4 read moves the reported state to C2 (code 2) on the next cycle.
- R3: In C0, a level-4 read moves the state to C4 (code 4). A level-3 read moves it to C3 (code 3) when the level-3-as-C4 bit is clear, and to C4 when that bit is set. Priority is level 4, then level 3, then level 2, then auto-halt.
- R4: In C0, an auto-halt with no register read moves the state to C1 (code 1). C1 raises no sideband line.
- R5: Register-read strobes and auto-halt are ignored in every state other than C0.
- R6: In C3 or C4, a snoop request moves the state to C2 on the next cycle only when the snoop-enable bit is set. Otherwise the state does not change.
- R7: During a snoop excursion the state stays in C2 while the request is held. The cycle after the request drops, the state returns to C3 or C4, whichever it left. A level-2 C2 ignores snoop requests.
- R8: A break event in C1, C2, C3 or C4 returns the state to C0 on the next cycle, even when a snoop request arrives in the same cycle.
- R9: The target depth is 0 for C0 and C1, 1 for C2, 2 for C3 and 3 for C4. Stop-clock is high at depth 1 or more, stop-CPU-clock at depth 2 or more, and deeper-sleep at depth 3. The depth moves one step per cycle toward the target of the current state, so the lines rise in that order and fall in reverse order.
- R10: The low-voltage line is high exactly while the state is C4. The C4 alert is high in C4 and stays high during a snoop excursion taken from C4. The pair {alert, low-voltage} = 10 means a slow ramp up, and 00 means normal voltage.
- R11: A done pulse is high for exactly one cycle: the first cycle in which the state reads C0 after any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_lvl2 | input | 1 | Level-2 idle register read strobe |
| rd_lvl3 | input | 1 | Level-3 idle register read strobe |
| rd_lvl4 | input | 1 | Level-4 idle register read strobe |
| auto_halt | input | 1 | Processor auto-halt indication |
| snoop_req | input | 1 | Bus-master snoop request (level) |
| break_evt | input | 1 | Break event, single-cycle pulse |
| cfg_l3_as_c4 | input | 1 | A level-3 read enters C4 |
| cfg_snoop_c2 | input | 1 | Allow the snoop excursion to C2 |
| c_state | output | 3 | Current state code, 0 to 4 |
| stop_clk | output | 1 | Halt instruction stream |
| stop_cpu_clk | output | 1 | Stop processor clock |
| deep_sleep | output | 1 | Deeper-sleep request |
| vrm_low_v | output | 1 | Regulator low-voltage request |
| c4_alert | output | 1 | C4 alert / ramp-speed select |
| exit_done | output | 1 | Pulse on re-entry to C0 |

## Verification
The state, the low-voltage line, the C4 alert and the done pulse all take effect one cycle after the inputs that cause them. Each sideband ladder line changes one cycle after the state that sets its new target, and then one cycle per further step. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge. It keeps a cycle-accurate reference that advances once per sampled edge and compares every output on every cycle. This covers every combination of configuration bits, entry kind and exit path, so multi-cycle ladder ramps are checked at each intermediate step.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

    typedef enum logic [2:0] {
        CS_C0 = 3'd0,
        CS_C1 = 3'd1,
        CS_C2 = 3'd2,
        CS_C3 = 3'd3,
        CS_C4 = 3'd4
    } cstate_e;

    parameter int LADDER_STEPS = 3;
    parameter int LVL_W        = $clog2(LADDER_STEPS + 1);

    typedef struct packed {
        logic rd_l2;
        logic rd_l3;
        logic rd_l4;
        logic halt;
        logic snoop;
        logic brk;
    } cs_evt_t;

    typedef struct packed {
        logic in_exc;
        logic from_c4;
    } exc_rec_t;

    typedef struct packed {
        logic stpclk;
        logic stpcpu;
        logic dpslp;
    } ladder_t;

    function automatic logic [LVL_W-1:0] depth_of(cstate_e s);
        case (s)
            CS_C2:   return LVL_W'(1);
            CS_C3:   return LVL_W'(2);
            CS_C4:   return LVL_W'(3);
            default: return '0;
        endcase
    endfunction

    function automatic logic is_deep(cstate_e s);
        return (s == CS_C3) || (s == CS_C4);
    endfunction

endpackage

// File: rtl/cstate_fsm.sv
module cstate_fsm
    import cstate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cs_evt_t  ev,
    input  logic     cfg_l3_as_c4,
    input  logic     cfg_snoop_c2,
    output cstate_e  state_q,
    output cstate_e  state_d,
    output exc_rec_t rec_q,
    output exc_rec_t rec_d
);

    always_comb begin
        state_d = state_q;
        rec_d   = rec_q;
        case (state_q)
            CS_C0: begin
                if (ev.rd_l4 || (ev.rd_l3 && cfg_l3_as_c4)) state_d = CS_C4;
                else if (ev.rd_l3)                          state_d = CS_C3;
                else if (ev.rd_l2)                          state_d = CS_C2;
                else if (ev.halt)                           state_d = CS_C1;
            end
            CS_C1: begin
                if (ev.brk) state_d = CS_C0;
            end
            CS_C2: begin
                if (ev.brk) begin
                    state_d = CS_C0;
                end else if (rec_q.in_exc && !ev.snoop) begin
                    state_d      = rec_q.from_c4 ? CS_C4 : CS_C3;
                    rec_d.in_exc = 1'b0;
                end
            end
            CS_C3, CS_C4: begin
                if (ev.brk) begin
                    state_d = CS_C0;
                end else if (ev.snoop && cfg_snoop_c2) begin
                    state_d       = CS_C2;
                    rec_d.in_exc  = 1'b1;
                    rec_d.from_c4 = (state_q == CS_C4);
                end
            end
            default: state_d = CS_C0;
        endcase
        if (state_d == CS_C0) rec_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_C0;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
        end
    end

    // R2: level-2 read from C0 lands in C2
    assert_l2_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_C0 && ev.rd_l2 && !ev.rd_l3 && !ev.rd_l4) |=> (state_q == CS_C2));

    // R3: level-4 read from C0 lands in C4
    assert_l4_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_C0 && ev.rd_l4) |=> (state_q == CS_C4));

    // R5: strobes do not move C1
    assert_c1_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_C1 && !ev.brk) |=> (state_q == CS_C1));

    // R6: enabled snoop lifts a deep state to C2
    assert_snoop_lift_R6: assert property (@(posedge clk) disable iff (rst)
        (is_deep(state_q) && ev.snoop && cfg_snoop_c2 && !ev.brk) |=> (state_q == CS_C2));

    // R7: end of excursion resumes the recorded deep state
    assert_resume_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_C2 && rec_q.in_exc && !ev.snoop && !ev.brk)
        |=> (state_q == ($past(rec_q.from_c4) ? CS_C4 : CS_C3)));

    // R8: break wins and returns to C0
    assert_break_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != CS_C0 && ev.brk) |=> (state_q == CS_C0));

endmodule

// File: rtl/cstate_ladder.sv
module cstate_ladder
    import cstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cstate_e state_q,
    output ladder_t lad
);

    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] tgt;

    assign tgt = depth_of(state_q);

    always_ff @(posedge clk) begin
        if (rst)              lvl_q <= '0;
        else if (lvl_q < tgt) lvl_q <= lvl_q + LVL_W'(1);
        else if (lvl_q > tgt) lvl_q <= lvl_q - LVL_W'(1);
    end

    assign lad.stpclk = (lvl_q >= LVL_W'(1));
    assign lad.stpcpu = (lvl_q >= LVL_W'(2));
    assign lad.dpslp  = (lvl_q >= LVL_W'(3));

    // R9: depth moves by at most one step per cycle
    assert_one_step_R9: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |->
        (((lvl_q - $past(lvl_q)) == LVL_W'(1)) || (($past(lvl_q) - lvl_q) == LVL_W'(1))));

    // R9: stop-CPU-clock never rises without stop-clock already up
    assert_order_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lad.stpcpu) |-> $past(lad.stpclk));

endmodule

// File: rtl/cstate_vid.sv
module cstate_vid
    import cstate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cstate_e  state_q,
    input  cstate_e  state_d,
    input  exc_rec_t rec_d,
    output logic     vrm_low_v,
    output logic     c4_alert,
    output logic     exit_done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vrm_low_v <= 1'b0;
            c4_alert  <= 1'b0;
            exit_done <= 1'b0;
        end else begin
            vrm_low_v <= (state_d == CS_C4);
            c4_alert  <= (state_d == CS_C4) ||
                         (state_d == CS_C2 && rec_d.in_exc && rec_d.from_c4);
            exit_done <= (state_d == CS_C0) && (state_q != CS_C0);
        end
    end

    // R10: low-voltage request tracks C4 exactly
    assert_vrm_c4_R10: assert property (@(posedge clk) disable iff (rst)
        vrm_low_v == (state_q == CS_C4));

    // R10: low voltage never without alert
    assert_alert_R10: assert property (@(posedge clk) disable iff (rst)
        vrm_low_v |-> c4_alert);

    // R11: done only on first C0 cycle
    assert_done_R11: assert property (@(posedge clk) disable iff (rst)
        exit_done |-> (state_q == CS_C0 && $past(state_q) != CS_C0));

endmodule

// File: rtl/cstate_seq.sv
module cstate_seq
    import cstate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_lvl2,
    input  logic       rd_lvl3,
    input  logic       rd_lvl4,
    input  logic       auto_halt,
    input  logic       snoop_req,
    input  logic       break_evt,
    input  logic       cfg_l3_as_c4,
    input  logic       cfg_snoop_c2,
    output logic [2:0] c_state,
    output logic       stop_clk,
    output logic       stop_cpu_clk,
    output logic       deep_sleep,
    output logic       vrm_low_v,
    output logic       c4_alert,
    output logic       exit_done
);

    cs_evt_t  ev;
    cstate_e  st_q, st_d;
    exc_rec_t rec_q, rec_d;
    ladder_t  lad;

    assign ev = '{rd_l2: rd_lvl2, rd_l3: rd_lvl3, rd_l4: rd_lvl4,
                  halt: auto_halt, snoop: snoop_req, brk: break_evt};

    cstate_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .cfg_l3_as_c4 (cfg_l3_as_c4),
        .cfg_snoop_c2 (cfg_snoop_c2),
        .state_q      (st_q),
        .state_d      (st_d),
        .rec_q        (rec_q),
        .rec_d        (rec_d)
    );

    cstate_ladder u_ladder (
        .clk     (clk),
        .rst     (rst),
        .state_q (st_q),
        .lad     (lad)
    );

    cstate_vid u_vid (
        .clk       (clk),
        .rst       (rst),
        .state_q   (st_q),
        .state_d   (st_d),
        .rec_d     (rec_d),
        .vrm_low_v (vrm_low_v),
        .c4_alert  (c4_alert),
        .exit_done (exit_done)
    );

    assign c_state      = st_q;
    assign stop_clk     = lad.stpclk;
    assign stop_cpu_clk = lad.stpcpu;
    assign deep_sleep   = lad.dpslp;

endmodule

// File: tb/cstate_seq_bench.sv
module cstate_seq_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, rd_lvl2, rd_lvl3, rd_lvl4, auto_halt, snoop_req, break_evt;
    logic cfg_l3_as_c4, cfg_snoop_c2;
    logic [2:0] c_state;
    logic stop_clk, stop_cpu_clk, deep_sleep, vrm_low_v, c4_alert, exit_done;

    cstate_seq u_cstate_seq (
        .clk(clk), .rst(rst), .rd_lvl2(rd_lvl2), .rd_lvl3(rd_lvl3), .rd_lvl4(rd_lvl4),
        .auto_halt(auto_halt), .snoop_req(snoop_req), .break_evt(break_evt),
        .cfg_l3_as_c4(cfg_l3_as_c4), .cfg_snoop_c2(cfg_snoop_c2),
        .c_state(c_state), .stop_clk(stop_clk), .stop_cpu_clk(stop_cpu_clk),
        .deep_sleep(deep_sleep), .vrm_low_v(vrm_low_v), .c4_alert(c4_alert),
        .exit_done(exit_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_st = 0, m_exc = 0, m_c4 = 0, m_lvl = 0;
    int m_vrm = 0, m_alert = 0, m_done = 0;

    function automatic int tgt_of(int s);
        return (s == 2) ? 1 : (s == 3) ? 2 : (s == 4) ? 3 : 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag,   "state",        int'(c_state),      m_st);
        chk("R9",  "stop_clk",     int'(stop_clk),     int'(m_lvl >= 1));
        chk("R9",  "stop_cpu_clk", int'(stop_cpu_clk), int'(m_lvl >= 2));
        chk("R9",  "deep_sleep",   int'(deep_sleep),   int'(m_lvl >= 3));
        chk("R10", "vrm_low_v",    int'(vrm_low_v),    m_vrm);
        chk("R10", "c4_alert",     int'(c4_alert),     m_alert);
        chk("R11", "exit_done",    int'(exit_done),    m_done);
    endtask

    task automatic step(input bit l2, input bit l3, input bit l4, input bit h,
                        input bit sn, input bit br, input string tag);
        int ot, nt, nexc, nc4, tg;
        @(negedge clk);
        rd_lvl2 = l2; rd_lvl3 = l3; rd_lvl4 = l4;
        auto_halt = h; snoop_req = sn; break_evt = br;
        @(posedge clk);
        #1;
        ot = m_st; nt = ot; nexc = m_exc; nc4 = m_c4;
        case (ot)
            0: begin
                if (l4 || (l3 && cfg_l3_as_c4)) nt = 4;
                else if (l3) nt = 3;
                else if (l2) nt = 2;
                else if (h)  nt = 1;
            end
            1: if (br) nt = 0;
            2: begin
                if (br) nt = 0;
                else if (m_exc != 0 && !sn) begin
                    nt = (m_c4 != 0) ? 4 : 3;
                    nexc = 0;
                end
            end
            default: begin
                if (br) nt = 0;
                else if (sn && cfg_snoop_c2) begin
                    nt = 2; nexc = 1; nc4 = (ot == 4) ? 1 : 0;
                end
            end
        endcase
        if (nt == 0) begin nexc = 0; nc4 = 0; end
        tg = tgt_of(ot);
        if (m_lvl < tg) m_lvl++;
        else if (m_lvl > tg) m_lvl--;
        m_vrm   = (nt == 4) ? 1 : 0;
        m_alert = (nt == 4 || (nt == 2 && nexc != 0 && nc4 != 0)) ? 1 : 0;
        m_done  = (nt == 0 && ot != 0) ? 1 : 0;
        m_st = nt; m_exc = nexc; m_c4 = nc4;
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; rd_lvl2 = 0; rd_lvl3 = 0; rd_lvl4 = 0; auto_halt = 0;
        snoop_req = 0; break_evt = 0; cfg_l3_as_c4 = 0; cfg_snoop_c2 = 0;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        @(negedge clk);
        rst = 0;
        idle(1, "R1");

        // directed priority cases (R3)
        step(1, 1, 1, 1, 0, 0, "R3");
        idle(4, "R3");
        step(0, 0, 0, 0, 0, 1, "R8");
        idle(3, "R9");
        step(1, 0, 0, 1, 0, 0, "R2");
        idle(2, "R2");
        step(0, 0, 0, 0, 1, 0, "R7");
        idle(1, "R7");
        step(0, 0, 0, 0, 0, 1, "R8");
        idle(3, "R11");

        for (int cfg = 0; cfg < 4; cfg++) begin
            @(negedge clk);
            cfg_l3_as_c4 = cfg[0];
            cfg_snoop_c2 = cfg[1];
            for (int entry = 0; entry < 4; entry++) begin
                for (int ex = 0; ex < 3; ex++) begin
                    case (entry)
                        0: step(1, 0, 0, 0, 0, 0, "R2");
                        1: step(0, 1, 0, 0, 0, 0, "R3");
                        2: step(0, 0, 1, 0, 0, 0, "R3");
                        default: step(0, 0, 0, 1, 0, 0, "R4");
                    endcase
                    idle(4, "R9");
                    step(1, 1, 1, 1, 0, 0, "R5");
                    step(1, 0, 0, 0, 0, 0, "R5");
                    idle(1, "R5");
                    case (ex)
                        0: step(0, 0, 0, 0, 0, 1, "R8");
                        1: begin
                            step(0, 0, 0, 0, 1, 0, "R6");
                            step(1, 1, 1, 0, 1, 0, "R5");
                            step(0, 0, 0, 0, 1, 0, "R6");
                            idle(4, "R7");
                            step(0, 0, 0, 0, 0, 1, "R8");
                        end
                        default: step(0, 0, 0, 0, 1, 1, "R8");
                    endcase
                    idle(4, "R11");
                end
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule